// File: doc/BRIEF.md
# Multichannel ADC Scan Controller

This block is the host-side master for a four-wire serial sampling ADC with a 16-bit result. It derives a serial clock from the system clock by a fixed divider, drives chip select and the serial data line, and reads the converter's serial output. While a scan runs, it walks a programmable list of input channels. For each entry it builds an eight-bit command (start marker, multiplexer address, input mode, power mode) and returns every 16-bit result with the channel number it came from.

Two frame layouts are offered. In the compact layout each conversion costs 24 serial clocks: the start marker of the next command goes out on the same rising edge that captures the previous result's last bit. In the padded layout each conversion costs 32 clocks, and the final seven are filler. A stop request lets the frame in flight complete. In the compact layout one extra all-zero byte follows to collect the last result. Chip select then rises.

Top module: `adc_scan_ctrl`

## Requirements
- R1: After reset, cs_n_o is high, sclk_o and mosi_o are low and smp_valid_o is low.
- R2: Each command is shifted out most significant bit first as: 1, A2, A1, A0, 0, S, P1, P0. For a list entry ch, A2=ch[0], A1=ch[2] and A0=ch[1]. S is 1 when diff_i was 0 and 0 otherwise. P1:P0 equal pmode_i.
- R3: Every high phase and every low phase of sclk_o lasts exactly DIV system cycles. cs_n_o falls at least DIV cycles before the first rising edge of sclk_o. mosi_o changes while cs_n_o stays low only in the cycle in which sclk_o falls.
- R4: The result is sampled from miso_i on rising edges 10 to 25 of a frame, counted from 1, most significant bit first. It is presented on smp_data_o with a one-cycle smp_valid_o pulse.
- R5: With overlap_i=1 a frame has 24 rising edges. The next frame's start marker shares the edge that samples the previous result's last bit. The first result after start belongs to list entry 0.
- R6: With overlap_i=0 a frame has 32 rising edges, and mosi_o is 0 on the edges after the command.
- R7: The list holds 2**LIST_AW entries, written through the write port. A scan visits entries 0 to list_len_i-1 in order and wraps. A length of 0 selects every entry. smp_ch_o carries the channel number of the entry that was converted.
- R8: A stop request finishes the current frame. In compact mode, 8 more rising edges with mosi_o=0 follow. cs_n_o then rises and every started conversion has been delivered. A stop request while idle has no effect.
- R9: The mode, power and length inputs are captured when a scan starts. Changing them during the scan, or requesting start again, does not alter the scan.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin a scan when idle |
| stop_i | input | 1 | Request the scan to end |
| overlap_i | input | 1 | 1: 24-clock frames, 0: 32-clock frames |
| diff_i | input | 1 | 1: differential input pairs, 0: single-ended |
| pmode_i | input | 2 | Power mode bits placed in the command |
| list_len_i | input | LIST_AW | Number of list entries to scan, 0 means all |
| list_wr_i | input | 1 | Write strobe for the channel list |
| list_wr_idx_i | input | LIST_AW | List entry being written |
| list_wr_ch_i | input | 3 | Channel number to store |
| sclk_o | output | 1 | Serial clock to the converter |
| cs_n_o | output | 1 | Active-low chip select |
| mosi_o | output | 1 | Command bits to the converter |
| miso_i | input | 1 | Result bits from the converter |
| smp_valid_o | output | 1 | One-cycle result strobe |
| smp_ch_o | output | 3 | Channel number of the result |
| smp_data_o | output | DATA_W | Conversion result |

## Verification
The bench models the converter: it waits for a start marker, answers one idle slot after the command and then shifts out a word made of the received command and a conversion count. A wrong address permutation, mode bit or power field therefore shows up directly in the returned data. A design that sampled one edge early or late would return a shifted word. A design that dropped the tail byte would lose the final result or leave it mismatched, and wrong frame lengths show in the counted rising edges per scan. The bench also disturbs the configuration and pulses start in the middle of a scan, which catches a design that rereads its inputs. It measures every clock phase and the chip-select lead time in system cycles.

// File: rtl/adc_scan_pkg.sv
package adc_scan_pkg;

  // Command byte length and channel number width are fixed by the serial format.
  localparam int CTRL_BITS = 8;
  localparam int CH_W      = 3;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_TAIL = 2'd2
  } scan_state_e;

  // Multiplexer address bits are a permutation of the channel number.
  function automatic logic [CTRL_BITS-1:0] make_ctrl(
    input logic [CH_W-1:0] ch,
    input logic            diff,
    input logic [1:0]      pm
  );
    return {1'b1, ch[0], ch[2], ch[1], 1'b0, ~diff, pm};
  endfunction

endpackage

// File: rtl/adc_scan_sclk.sv
module adc_scan_sclk #(
  parameter int DIV = 50
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_i,
  output logic sclk_o,
  output logic rise_o,
  output logic fall_o
);

  localparam int CNT_W = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(DIV - 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             ph_q, ph_d;
  logic             last;

  assign last   = (cnt_q == CNT_LAST);
  assign rise_o = run_i & last & ~ph_q;
  assign fall_o = run_i & last &  ph_q;
  assign sclk_o = ph_q;

  always_comb begin
    cnt_d = cnt_q;
    ph_d  = ph_q;
    if (!run_i) begin
      cnt_d = '0;
      ph_d  = 1'b0;
    end else if (last) begin
      cnt_d = '0;
      ph_d  = ~ph_q;
    end else begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      ph_q  <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      ph_q  <= ph_d;
    end
  end

endmodule

// File: rtl/adc_scan_chlist.sv
module adc_scan_chlist
  import adc_scan_pkg::*;
#(
  parameter int LIST_AW = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en_i,
  input  logic [LIST_AW-1:0] wr_idx_i,
  input  logic [CH_W-1:0]    wr_ch_i,
  input  logic [LIST_AW-1:0] rd_idx_i,
  output logic [CH_W-1:0]    rd_ch_o
);

  localparam int DEPTH = 1 << LIST_AW;

  logic [CH_W-1:0] ent_q [DEPTH];
  logic [DEPTH-1:0] wr_sel;

  for (genvar e = 0; e < DEPTH; e++) begin : g_sel
    assign wr_sel[e] = wr_en_i && (wr_idx_i == LIST_AW'(e));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int e = 0; e < DEPTH; e++) ent_q[e] <= '0;
    end else begin
      for (int e = 0; e < DEPTH; e++) begin
        if (wr_sel[e]) ent_q[e] <= wr_ch_i;
      end
    end
  end

  assign rd_ch_o = ent_q[rd_idx_i];

endmodule

// File: rtl/adc_scan_capture.sv
module adc_scan_capture
  import adc_scan_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rise_i,
  input  logic              begin_i,
  input  logic [CH_W-1:0]   ch_i,
  input  logic              miso_i,
  output logic              valid_o,
  output logic [CH_W-1:0]   ch_o,
  output logic [DATA_W-1:0] data_o
);

  localparam int BC_W = $clog2(DATA_W + 1);
  localparam logic [BC_W-1:0] BC_LAST = BC_W'(DATA_W - 1);

  logic              act_q, act_d;
  logic [BC_W-1:0]   cnt_q, cnt_d;
  logic [DATA_W-1:0] sh_q, sh_d;
  logic [CH_W-1:0]   tag_q, tag_d;
  logic              vld_q, vld_d;
  logic [DATA_W-1:0] out_q, out_d;
  logic [CH_W-1:0]   och_q, och_d;

  always_comb begin
    act_d = act_q;
    cnt_d = cnt_q;
    sh_d  = sh_q;
    tag_d = tag_q;
    vld_d = 1'b0;
    out_d = out_q;
    och_d = och_q;
    if (rise_i && begin_i) begin
      act_d = 1'b1;
      cnt_d = BC_W'(1);
      sh_d  = {{(DATA_W-1){1'b0}}, miso_i};
      tag_d = ch_i;
    end else if (rise_i && act_q) begin
      sh_d = {sh_q[DATA_W-2:0], miso_i};
      if (cnt_q == BC_LAST) begin
        act_d = 1'b0;
        cnt_d = '0;
        vld_d = 1'b1;
        out_d = {sh_q[DATA_W-2:0], miso_i};
        och_d = tag_q;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q <= 1'b0;
      cnt_q <= '0;
      sh_q  <= '0;
      tag_q <= '0;
      vld_q <= 1'b0;
      out_q <= '0;
      och_q <= '0;
    end else begin
      act_q <= act_d;
      cnt_q <= cnt_d;
      sh_q  <= sh_d;
      tag_q <= tag_d;
      vld_q <= vld_d;
      out_q <= out_d;
      och_q <= och_d;
    end
  end

  assign valid_o = vld_q;
  assign ch_o    = och_q;
  assign data_o  = out_q;

endmodule

// File: rtl/adc_scan_ctrl.sv
module adc_scan_ctrl
  import adc_scan_pkg::*;
#(
  parameter int DIV     = 50,
  parameter int LIST_AW = 3,
  parameter int DATA_W  = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start_i,
  input  logic               stop_i,
  input  logic               overlap_i,
  input  logic               diff_i,
  input  logic [1:0]         pmode_i,
  input  logic [LIST_AW-1:0] list_len_i,
  input  logic               list_wr_i,
  input  logic [LIST_AW-1:0] list_wr_idx_i,
  input  logic [2:0]         list_wr_ch_i,
  output logic               sclk_o,
  output logic               cs_n_o,
  output logic               mosi_o,
  input  logic               miso_i,
  output logic               smp_valid_o,
  output logic [2:0]         smp_ch_o,
  output logic [DATA_W-1:0]  smp_data_o
);

  localparam int OVL_LEN  = CTRL_BITS + DATA_W;
  localparam int FULL_LEN = ((CTRL_BITS + 1 + DATA_W + 7) / 8) * 8;
  localparam int SLOT_W   = $clog2(FULL_LEN);
  localparam logic [SLOT_W-1:0] OVL_LAST   = SLOT_W'(OVL_LEN - 1);
  localparam logic [SLOT_W-1:0] FULL_LAST  = SLOT_W'(FULL_LEN - 1);
  localparam logic [SLOT_W-1:0] TAIL_LAST  = SLOT_W'(CTRL_BITS - 1);
  localparam logic [SLOT_W-1:0] CTRL_END   = SLOT_W'(CTRL_BITS);
  localparam logic [SLOT_W-1:0] DATA_FIRST = SLOT_W'(CTRL_BITS + 1);

  scan_state_e        st_q, st_d;
  logic [SLOT_W-1:0]  slot_q, slot_d, slot_nx;
  logic [LIST_AW-1:0] idx_q, idx_d, idx_nx, idx_last;
  logic [LIST_AW-1:0] len_q, len_d;
  logic               stop_q, stop_d;
  logic               ovl_q, ovl_d;
  logic               diff_q, diff_d;
  logic [1:0]         pm_q, pm_d;
  logic               cs_n_q, cs_n_d;
  logic               mosi_q, mosi_d;

  logic               run, rise, fall;
  logic               frame_last, cap_begin;
  logic [CH_W-1:0]    cur_ch;
  logic [CTRL_BITS-1:0] ctrl_byte;

  assign run = (st_q != ST_IDLE);

  adc_scan_sclk #(.DIV(DIV)) u_sclk (
    .clk    (clk),
    .rst_n  (rst_n),
    .run_i  (run),
    .sclk_o (sclk_o),
    .rise_o (rise),
    .fall_o (fall)
  );

  adc_scan_chlist #(.LIST_AW(LIST_AW)) u_list (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en_i  (list_wr_i),
    .wr_idx_i (list_wr_idx_i),
    .wr_ch_i  (list_wr_ch_i),
    .rd_idx_i (idx_q),
    .rd_ch_o  (cur_ch)
  );

  assign cap_begin = (st_q == ST_RUN) && (slot_q == DATA_FIRST);

  adc_scan_capture #(.DATA_W(DATA_W)) u_cap (
    .clk     (clk),
    .rst_n   (rst_n),
    .rise_i  (rise),
    .begin_i (cap_begin),
    .ch_i    (cur_ch),
    .miso_i  (miso_i),
    .valid_o (smp_valid_o),
    .ch_o    (smp_ch_o),
    .data_o  (smp_data_o)
  );

  always_comb begin
    st_d   = st_q;
    slot_d = slot_q;
    idx_d  = idx_q;
    len_d  = len_q;
    stop_d = stop_q;
    ovl_d  = ovl_q;
    diff_d = diff_q;
    pm_d   = pm_q;
    cs_n_d = cs_n_q;
    mosi_d = mosi_q;

    ctrl_byte  = make_ctrl(cur_ch, diff_q, pm_q);
    slot_nx    = slot_q + 1'b1;
    idx_last   = len_q - 1'b1;
    idx_nx     = (idx_q == idx_last) ? '0 : idx_q + 1'b1;
    frame_last = ovl_q ? (slot_q == OVL_LAST) : (slot_q == FULL_LAST);

    unique case (st_q)
      ST_IDLE: begin
        if (start_i) begin
          st_d   = ST_RUN;
          slot_d = '0;
          idx_d  = '0;
          len_d  = list_len_i;
          stop_d = 1'b0;
          ovl_d  = overlap_i;
          diff_d = diff_i;
          pm_d   = pmode_i;
          cs_n_d = 1'b0;
          mosi_d = 1'b1;
        end
      end
      ST_RUN: begin
        if (stop_i) stop_d = 1'b1;
        if (fall) begin
          if (frame_last) begin
            slot_d = '0;
            if (stop_q || stop_i) begin
              mosi_d = 1'b0;
              if (ovl_q) begin
                st_d = ST_TAIL;
              end else begin
                st_d   = ST_IDLE;
                cs_n_d = 1'b1;
              end
            end else begin
              idx_d  = idx_nx;
              mosi_d = 1'b1;
            end
          end else begin
            slot_d = slot_nx;
            if (slot_nx < CTRL_END)
              mosi_d = ctrl_byte[3'(CTRL_BITS - 1) - slot_nx[2:0]];
            else
              mosi_d = 1'b0;
          end
        end
      end
      ST_TAIL: begin
        mosi_d = 1'b0;
        if (fall) begin
          if (slot_q == TAIL_LAST) begin
            st_d   = ST_IDLE;
            slot_d = '0;
            cs_n_d = 1'b1;
          end else begin
            slot_d = slot_nx;
          end
        end
      end
      default: begin
        st_d   = ST_IDLE;
        cs_n_d = 1'b1;
        mosi_d = 1'b0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      slot_q <= '0;
      idx_q  <= '0;
      len_q  <= '0;
      stop_q <= 1'b0;
      ovl_q  <= 1'b0;
      diff_q <= 1'b0;
      pm_q   <= 2'b00;
      cs_n_q <= 1'b1;
      mosi_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      slot_q <= slot_d;
      idx_q  <= idx_d;
      len_q  <= len_d;
      stop_q <= stop_d;
      ovl_q  <= ovl_d;
      diff_q <= diff_d;
      pm_q   <= pm_d;
      cs_n_q <= cs_n_d;
      mosi_q <= mosi_d;
    end
  end

  assign cs_n_o = cs_n_q;
  assign mosi_o = mosi_q;

endmodule

// File: rtl/adc_scan_ctrl_chk.sv
module adc_scan_ctrl_chk #(
  parameter int DIV = 50
) (
  input logic clk,
  input logic rst_n,
  input logic cs_n_o,
  input logic sclk_o,
  input logic mosi_o,
  input logic smp_valid_o
);

  logic [15:0] hi_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_cnt <= '0;
    end else if (sclk_o) begin
      if (hi_cnt != 16'hFFFF) hi_cnt <= hi_cnt + 1'b1;
    end else begin
      hi_cnt <= '0;
    end
  end

  // R1 and R3: the serial clock idles low whenever the converter is deselected.
  a_r1_sclk_low_deselected: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n_o |-> !sclk_o);

  // R3: rising clock edges occur only while selected.
  a_r3_rise_selected: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sclk_o) |-> !cs_n_o);

  // R3: a high phase lasts exactly DIV system cycles.
  a_r3_high_width: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sclk_o) |-> (hi_cnt == 16'(DIV)));

  // R3: within a selected stretch the data line moves only with a falling clock.
  a_r3_mosi_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(mosi_o) && !cs_n_o && $past(!cs_n_o)) |-> $fell(sclk_o));

  // R2: the first bit presented after selection is the start marker.
  a_r2_start_marker: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cs_n_o) |-> mosi_o);

  // R4: the result strobe is a single-cycle pulse.
  a_r4_valid_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    smp_valid_o |=> !smp_valid_o);

endmodule

bind adc_scan_ctrl adc_scan_ctrl_chk #(.DIV(DIV)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .cs_n_o      (cs_n_o),
  .sclk_o      (sclk_o),
  .mosi_o      (mosi_o),
  .smp_valid_o (smp_valid_o)
);

// File: tb/adc_scan_ctrl_tb_top.sv
`timescale 1ns/1ps
module adc_scan_ctrl_tb_top;

  localparam int DIV      = 50;
  localparam int LIST_AW  = 3;
  localparam int DATA_W   = 16;
  localparam int WD_LIMIT = 180000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_i = 1'b0, stop_i = 1'b0, overlap_i = 1'b0, diff_i = 1'b0;
  logic [1:0] pmode_i = 2'b00;
  logic [LIST_AW-1:0] list_len_i = '0;
  logic list_wr_i = 1'b0;
  logic [LIST_AW-1:0] list_wr_idx_i = '0;
  logic [2:0] list_wr_ch_i = '0;
  logic sclk_o, cs_n_o, mosi_o;
  logic miso = 1'b0;
  logic smp_valid_o;
  logic [2:0] smp_ch_o;
  logic [DATA_W-1:0] smp_data_o;

  always #2 clk = ~clk;

  adc_scan_ctrl #(.DIV(DIV), .LIST_AW(LIST_AW), .DATA_W(DATA_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .stop_i(stop_i),
    .overlap_i(overlap_i), .diff_i(diff_i), .pmode_i(pmode_i),
    .list_len_i(list_len_i), .list_wr_i(list_wr_i),
    .list_wr_idx_i(list_wr_idx_i), .list_wr_ch_i(list_wr_ch_i),
    .sclk_o(sclk_o), .cs_n_o(cs_n_o), .mosi_o(mosi_o), .miso_i(miso),
    .smp_valid_o(smp_valid_o), .smp_ch_o(smp_ch_o), .smp_data_o(smp_data_o)
  );

  int checks = 0;
  int errors = 0;
  bit fin = 1'b0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // Converter model: command in on rising edges, result out on falling edges.
  bit        in_frame = 1'b0;
  int        bcnt = 0;
  logic [7:0] sr = '0;
  int        out_cnt = 0;
  logic [15:0] out_word = '0;
  logic [7:0] mdl_seq = '0;

  always @(posedge sclk_o) begin
    if (!cs_n_o) begin
      if (!in_frame) begin
        if (mosi_o) begin
          in_frame = 1'b1;
          bcnt = 1;
          sr = 8'h01;
        end
      end else begin
        sr = {sr[6:0], mosi_o};
        bcnt++;
        if (bcnt == 8) begin
          out_word = {sr, mdl_seq};
          mdl_seq = mdl_seq + 8'd1;
          out_cnt = 17;
          in_frame = 1'b0;
        end
      end
    end
  end

  always @(negedge sclk_o) begin
    if (out_cnt > 0) begin
      miso = (out_cnt == 17) ? 1'b0 : out_word[out_cnt-1];
      out_cnt--;
    end else begin
      miso = 1'b0;
    end
  end

  always @(posedge cs_n_o) in_frame = 1'b0;

  // Scoreboard
  typedef struct packed {
    logic [2:0]  ch;
    logic [15:0] data;
  } exp_t;
  exp_t q[$];
  int got = 0;

  always @(negedge clk) begin
    if (rst_n && smp_valid_o) begin
      got++;
      if (q.size() == 0) begin
        chk(1'b0, "R4", "unexpected sample", smp_data_o, 0);
      end else begin
        exp_t e;
        e = q.pop_front();
        chk(smp_ch_o == e.ch, "R5 R7", "channel tag", smp_ch_o, e.ch);
        chk(smp_data_o == e.data, "R2 R4 R9", "sample data", smp_data_o, e.data);
      end
    end
  end

  // Clock phase and edge monitor
  int edge_cnt = 0;
  logic sclk_prev = 1'b0, cs_prev = 1'b1;
  int run_len = 0;
  bit lo_ok = 1'b0;
  int min_hi = 1000000, max_hi = 0, min_lo = 1000000, max_lo = 0;
  int lead = 0, min_lead = 1000000;
  bit lead_on = 1'b0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (sclk_o && !sclk_prev) edge_cnt++;
      if (sclk_o != sclk_prev) begin
        if (sclk_prev) begin
          if (run_len < min_hi) min_hi = run_len;
          if (run_len > max_hi) max_hi = run_len;
        end else if (lo_ok) begin
          if (run_len < min_lo) min_lo = run_len;
          if (run_len > max_lo) max_lo = run_len;
        end
        lo_ok = sclk_prev;
        run_len = 1;
      end else begin
        run_len++;
      end
      if (cs_n_o) lo_ok = 1'b0;
      if (cs_prev && !cs_n_o) begin
        lead = 0;
        lead_on = 1'b1;
      end
      if (lead_on) begin
        if (sclk_o && !sclk_prev) begin
          if (lead < min_lead) min_lead = lead;
          lead_on = 1'b0;
        end else begin
          lead++;
        end
      end
      sclk_prev = sclk_o;
      cs_prev = cs_n_o;
    end
  end

  // Watchdog
  int cyc = 0;
  always @(negedge clk) begin
    cyc++;
    if (cyc >= WD_LIMIT && !fin) begin
      fin = 1'b1;
      chk(1'b0, "R8", "watchdog expired", cyc, WD_LIMIT);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  logic [2:0] shadow [8];
  logic [7:0] exp_seq = '0;

  function automatic logic [2:0] addr_of(input logic [2:0] ch);
    case (ch)
      3'd0: return 3'b000;
      3'd1: return 3'b100;
      3'd2: return 3'b001;
      3'd3: return 3'b101;
      3'd4: return 3'b010;
      3'd5: return 3'b110;
      3'd6: return 3'b011;
      default: return 3'b111;
    endcase
  endfunction

  task automatic wr_list(input int idx, input logic [2:0] ch);
    @(negedge clk);
    list_wr_i = 1'b1;
    list_wr_idx_i = LIST_AW'(idx);
    list_wr_ch_i = ch;
    shadow[idx] = ch;
    @(negedge clk);
    list_wr_i = 1'b0;
  endtask

  task automatic run_scan(input bit ov, input bit df, input logic [1:0] pm,
                          input int n_ent, input int k, input bit disturb);
    int total;
    int e0;
    int g0;
    int exp_edges;
    total = ov ? k + 1 : k;
    for (int i = 0; i < total; i++) begin
      exp_t e;
      e.ch = shadow[i % n_ent];
      e.data = {1'b1, addr_of(e.ch), 1'b0, ~df, pm, exp_seq};
      exp_seq = exp_seq + 8'd1;
      q.push_back(e);
    end
    e0 = edge_cnt;
    g0 = got;
    @(negedge clk);
    overlap_i = ov;
    diff_i = df;
    pmode_i = pm;
    list_len_i = LIST_AW'(n_ent);
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    if (disturb) begin
      repeat (700) @(negedge clk);
      overlap_i = ~ov;
      diff_i = ~df;
      pmode_i = ~pm;
      list_len_i = LIST_AW'(1);
      start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
    end
    while (got - g0 < k) @(negedge clk);
    stop_i = 1'b1;
    @(negedge clk);
    stop_i = 1'b0;
    while (!cs_n_o) @(negedge clk);
    repeat (50) @(negedge clk);
    chk(q.size() == 0, "R8", "samples left undelivered", q.size(), 0);
    chk(got - g0 == total, "R8", "sample count", got - g0, total);
    exp_edges = ov ? 24 * total + 8 : 32 * total;
    chk(edge_cnt - e0 == exp_edges, ov ? "R5" : "R6", "rising edges in scan",
        edge_cnt - e0, exp_edges);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(cs_n_o == 1'b1, "R1", "cs_n after reset", cs_n_o, 1);
    chk(sclk_o == 1'b0, "R1", "sclk after reset", sclk_o, 0);
    chk(mosi_o == 1'b0, "R1", "mosi after reset", mosi_o, 0);
    chk(smp_valid_o == 1'b0, "R1", "valid after reset", smp_valid_o, 0);

    // R8 stop while idle has no effect
    begin
      int e0;
      e0 = edge_cnt;
      stop_i = 1'b1;
      @(negedge clk);
      stop_i = 1'b0;
      repeat (300) @(negedge clk);
      chk(cs_n_o == 1'b1, "R8", "cs_n after idle stop", cs_n_o, 1);
      chk(edge_cnt == e0, "R8", "edges after idle stop", edge_cnt - e0, 0);
    end

    // Scan A: compact frames, three entries, disturbed mid-scan (R5 R7 R9)
    wr_list(0, 3'd5);
    wr_list(1, 3'd2);
    wr_list(2, 3'd7);
    run_scan(1'b1, 1'b0, 2'b11, 3, 4, 1'b1);

    // Scan B: padded frames, length 0 selects all eight, list wraps (R6 R7)
    for (int i = 0; i < 8; i++) wr_list(i, 3'(i ^ 3));
    run_scan(1'b0, 1'b1, 2'b00, 8, 9, 1'b0);

    // Scan C: single entry, stop right after start (R5 R8)
    wr_list(0, 3'd6);
    run_scan(1'b1, 1'b0, 2'b10, 1, 0, 1'b0);

    // R3 clock phase widths and select lead time
    chk(min_hi == DIV, "R3", "shortest high phase", min_hi, DIV);
    chk(max_hi == DIV, "R3", "longest high phase", max_hi, DIV);
    chk(min_lo == DIV, "R3", "shortest low phase", min_lo, DIV);
    chk(max_lo == DIV, "R3", "longest low phase", max_lo, DIV);
    chk(min_lead >= DIV, "R3", "select to first rise", min_lead, DIV);

    fin = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule